// File: doc/BRIEF.md
# Dual-Channel Interrupt Collector

This block gathers the interrupt conditions of one two-channel serial block into an 8-bit status word. It combines that word with a mask the CPU can write, and drives one shared, active-low request line. The line is driven through an output-enable, so several such blocks can share one wired-OR line with a pull-up. The channel conditions come from outside as plain levels: transmitter ready, and receiver ready or FIFO full. The counter's terminal count is also a level. Changes in each channel's break-received state are caught here and held as sticky flags.

Two multi-purpose inputs pass through a two-stage synchroniser and a change-of-state filter that runs on a sample tick. A new level must be seen on two ticks in a row before it is accepted. An accepted level change sets a sticky flag. The flags and the filtered levels can be read through an input change register, and reading that register clears the flags. Software reads the status word at any time and sees every active condition, whatever the mask holds. The mask only decides whether the request line is pulled low.

Top module: `duo_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after its release: the mask is 0, every sticky flag is 0, irq_oe_o is 0 and irq_n_o is 1, and the filtered input levels are 1 (input change register reads 0x03).
- R2: Status bit positions: bit0 tx ready ch0, bit1 rx ready/full ch0, bit2 break change ch0, bit3 counter terminal count, bit4 tx ready ch1, bit5 rx ready/full ch1, bit6 break change ch1, bit7 OR of the two input change flags. Level sources appear in the same cycle.
- R3: With reg_sel_i = 0, rdata_o returns the full status word, whatever the mask holds.
- R4: irq_oe_o is 1 exactly when some status bit and its mask bit are both 1, in the same cycle; irq_n_o is always its inverse.
- R5: A write (wr_i) with reg_sel_i = 1 loads wdata_i into the mask at the clock edge. The mask reads back on rdata_o with reg_sel_i = 1 and acts on the request from the next cycle.
- R6: Any edge of brk_i[c], sampled at a clock edge, sets the break change flag of channel c. A brk_clr_i[c] pulse clears it. When a new edge and a clear arrive in the same cycle, the flag stays set.
- R7: mpi_i passes a two-flop synchroniser. The filtered level changes only at a clock edge where sample_tick_i is 1, and only after the new synchronised level has been seen on two consecutive ticks. A level seen on one tick only is discarded. Acceptance sets that input's change flag.
- R8: With reg_sel_i = 2, rdata_o bits 1:0 hold the filtered levels, bits 5:4 hold the change flags, and the other bits are 0. A read (rd_i) clears the flags at the clock edge, except for a flag whose input is accepted in that same cycle.
- R9: Writes with reg_sel_i of 0, 2 or 3 change nothing, and rdata_o is 0 with reg_sel_i = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_rdy_i | input | 2 | Transmitter ready level per channel |
| rx_rdy_i | input | 2 | Receiver ready or FIFO full level per channel |
| brk_i | input | 2 | Break-received state per channel |
| brk_clr_i | input | 2 | Clear pulse for the break change flag per channel |
| ct_done_i | input | 1 | Counter terminal count level |
| mpi_i | input | 2 | Asynchronous multi-purpose inputs |
| sample_tick_i | input | 1 | Enable for the change-of-state filter |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 input change, 3 unused |
| rd_i | input | 1 | Read strobe (side effects at clock edge) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_oe_o | output | 1 | Drive enable for the shared request line (1 = pull low) |
| irq_n_o | output | 1 | Active-low request level |

## Verification
The bench tries the status path with single sources held one at a time and then with several at once. This shows whether each condition lands in its own bit position and whether the masked request follows only the enabled bits. The input filter gets a one-tick glitch, a clean held change, and a change that is accepted in the same cycle as a clearing read. These three separate a filter that is too eager, one that never fires, and one that lets the clear win. Break edges in both directions, with and without a coincident clear, separate sticky latching from plain level following. A long random phase then mixes all of these against the cycle model.

// File: rtl/duo_irq_pkg.sv
package duo_irq_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned MPI_W = 2;
  localparam int unsigned DW    = 8;
  localparam int unsigned SELW  = 2;

  // per-channel bit layout inside the status word
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned OFS_TX    = 0;
  localparam int unsigned OFS_RX    = 1;
  localparam int unsigned OFS_BRK   = 2;
  localparam int unsigned BIT_CT    = 3;
  localparam int unsigned BIT_IN    = 7;

  // input change register layout
  localparam int unsigned ICR_LVL_LSB = 0;
  localparam int unsigned ICR_CHG_LSB = 4;

  typedef enum logic [SELW-1:0] {
    SEL_STAT  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_INCHG = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/duo_irq_sync.sv
module duo_irq_sync #(
  parameter int unsigned   W   = 2,
  parameter logic [W-1:0]  RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/duo_irq_cos.sv
module duo_irq_cos #(
  parameter int unsigned  W       = 2,
  parameter logic [W-1:0] RST_LVL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] evt_o
);
  for (genvar g = 0; g < W; g++) begin : g_in
    logic lvl_q, pend_q, diff;

    assign diff = sync_i[g] ^ lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q  <= RST_LVL[g];
        pend_q <= 1'b0;
      end else if (tick_i) begin
        if (diff && pend_q) begin
          lvl_q  <= sync_i[g];
          pend_q <= 1'b0;
        end else begin
          pend_q <= diff;
        end
      end
    end

    assign lvl_o[g] = lvl_q;
    // second consecutive tick with the new level
    assign evt_o[g] = tick_i & pend_q & diff;
  end
endmodule

// File: rtl/duo_irq_sticky.sv
module duo_irq_sticky #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign q_o = flag_q;
endmodule

// File: rtl/duo_irq_ctrl.sv
module duo_irq_ctrl
  import duo_irq_pkg::*;
#(
  parameter logic [MPI_W-1:0] MPI_RST_LVL = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  tx_rdy_i,
  input  logic [NCH-1:0]  rx_rdy_i,
  input  logic [NCH-1:0]  brk_i,
  input  logic [NCH-1:0]  brk_clr_i,
  input  logic            ct_done_i,
  input  logic [MPI_W-1:0] mpi_i,
  input  logic            sample_tick_i,
  input  logic [SELW-1:0] reg_sel_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_oe_o,
  output logic            irq_n_o
);
  logic [DW-1:0]    mask_q;
  logic [DW-1:0]    status_w;
  logic [DW-1:0]    icr_w;
  logic [NCH-1:0]   brk_q, brk_evt_w, brk_flag_w;
  logic [MPI_W-1:0] mpi_sync_w, mpi_lvl_w, cos_evt_w, cos_flag_w, cos_clr_w;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_sel_i);

  // break state edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= '0;
    else         brk_q <= brk_i;
  end
  assign brk_evt_w = brk_i ^ brk_q;

  duo_irq_sticky #(.W(NCH)) u_brk_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (brk_evt_w),
    .clr_i  (brk_clr_i),
    .q_o    (brk_flag_w)
  );

  duo_irq_sync #(.W(MPI_W), .RST(MPI_RST_LVL)) u_mpi_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mpi_i),
    .q_o    (mpi_sync_w)
  );

  duo_irq_cos #(.W(MPI_W), .RST_LVL(MPI_RST_LVL)) u_mpi_cos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (sample_tick_i),
    .sync_i (mpi_sync_w),
    .lvl_o  (mpi_lvl_w),
    .evt_o  (cos_evt_w)
  );

  assign cos_clr_w = {MPI_W{rd_i && sel == SEL_INCHG}};

  duo_irq_sticky #(.W(MPI_W)) u_cos_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cos_evt_w),
    .clr_i  (cos_clr_w),
    .q_o    (cos_flag_w)
  );

  // mask register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mask_q <= '0;
    else if (wr_i && sel == SEL_MASK)   mask_q <= wdata_i;
  end

  // status word assembly
  always_comb begin
    status_w = '0;
    for (int c = 0; c < NCH; c++) begin
      status_w[c*CH_STRIDE + OFS_TX]  = tx_rdy_i[c];
      status_w[c*CH_STRIDE + OFS_RX]  = rx_rdy_i[c];
      status_w[c*CH_STRIDE + OFS_BRK] = brk_flag_w[c];
    end
    status_w[BIT_CT] = ct_done_i;
    status_w[BIT_IN] = |cos_flag_w;
  end

  always_comb begin
    icr_w = '0;
    icr_w[ICR_LVL_LSB +: MPI_W] = mpi_lvl_w;
    icr_w[ICR_CHG_LSB +: MPI_W] = cos_flag_w;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT:  rdata_o = status_w;
      SEL_MASK:  rdata_o = mask_q;
      SEL_INCHG: rdata_o = icr_w;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_oe_o = |(status_w & mask_q);
  assign irq_n_o  = ~irq_oe_o;
endmodule

// File: rtl/duo_irq_chk.sv
module duo_irq_chk
  import duo_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCH-1:0]   tx_rdy_i,
  input logic [NCH-1:0]   rx_rdy_i,
  input logic [NCH-1:0]   brk_clr_i,
  input logic             ct_done_i,
  input logic             sample_tick_i,
  input logic [SELW-1:0]  reg_sel_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             irq_oe_o,
  input logic [DW-1:0]    status_w,
  input logic [NCH-1:0]   brk_evt_w,
  input logic [MPI_W-1:0] cos_evt_w,
  input logic [MPI_W-1:0] mpi_lvl_w
);
  // R3
  stat_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'(SEL_STAT)) |->
      (rdata_o[0] == tx_rdy_i[0] && rdata_o[1] == rx_rdy_i[0] && rdata_o[3] == ct_done_i &&
       rdata_o[4] == tx_rdy_i[1] && rdata_o[5] == rx_rdy_i[1]));

  // R5
  mask_rdbk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_sel_i == 2'(SEL_MASK)) |=>
      (reg_sel_i != 2'(SEL_MASK) || rdata_o == $past(wdata_i)));

  // R4
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_sel_i == 2'(SEL_MASK) && wdata_i == '0) |=> !irq_oe_o);

  // R6
  brk_clr0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_clr_i[0] && !brk_evt_w[0]) |=> !status_w[2]);

  // R6
  brk_clr1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_clr_i[1] && !brk_evt_w[1]) |=> !status_w[6]);

  // R8
  icr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && reg_sel_i == 2'(SEL_INCHG) && cos_evt_w == '0) |=> !status_w[7]);

  // R7
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_tick_i |=> $stable(mpi_lvl_w));

  // R9
  none_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'(SEL_NONE)) |-> (rdata_o == '0));
endmodule

bind duo_irq_ctrl duo_irq_chk u_chk (.*);

// File: tb/sim_duo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_duo_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] tx_rdy_i, rx_rdy_i, brk_i, brk_clr_i, mpi_i, reg_sel_i;
  logic       ct_done_i, sample_tick_i, rd_i, wr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       irq_oe_o, irq_n_o;

  always #2.5 clk_i = ~clk_i;

  duo_irq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_rdy_i(tx_rdy_i), .rx_rdy_i(rx_rdy_i),
    .brk_i(brk_i), .brk_clr_i(brk_clr_i), .ct_done_i(ct_done_i), .mpi_i(mpi_i),
    .sample_tick_i(sample_tick_i), .reg_sel_i(reg_sel_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_oe_o(irq_oe_o), .irq_n_o(irq_n_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  logic [7:0] m_mask;
  logic [1:0] m_bprev, m_bflag, m_s1, m_s2, m_lvl, m_seen, m_cflag;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mask = 8'h00; m_bprev = 2'b00; m_bflag = 2'b00;
      m_s1 = 2'b11; m_s2 = 2'b11; m_lvl = 2'b11; m_seen = 2'b00; m_cflag = 2'b00;
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit acc;
        if (brk_i[i] != m_bprev[i]) m_bflag[i] = 1'b1;
        else if (brk_clr_i[i])      m_bflag[i] = 1'b0;
        m_bprev[i] = brk_i[i];
        acc = 1'b0;
        if (sample_tick_i) begin
          if (m_s2[i] == m_lvl[i]) m_seen[i] = 1'b0;
          else if (m_seen[i]) begin
            m_lvl[i] = m_s2[i]; m_seen[i] = 1'b0; acc = 1'b1;
          end else m_seen[i] = 1'b1;
        end
        if (acc) m_cflag[i] = 1'b1;
        else if (rd_i && reg_sel_i == 2'd2) m_cflag[i] = 1'b0;
      end
      m_s2 = m_s1;
      m_s1 = mpi_i;
      if (wr_i && reg_sel_i == 2'd1) m_mask = wdata_i;
    end
  end

  function automatic logic [7:0] exp_stat();
    return {|m_cflag, m_bflag[1], rx_rdy_i[1], tx_rdy_i[1],
            ct_done_i, m_bflag[0], rx_rdy_i[0], tx_rdy_i[0]};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && !done) begin
      logic [7:0] st, ex;
      string tg;
      st = exp_stat();
      case (reg_sel_i)
        2'd0: begin ex = st;                          tg = "R3 status read"; end
        2'd1: begin ex = m_mask;                      tg = "R5 mask read"; end
        2'd2: begin ex = {2'b00, m_cflag, 2'b00, m_lvl}; tg = "R8 input change read"; end
        default: begin ex = 8'h00;                    tg = "R9 unused read"; end
      endcase
      chk(tg, rdata_o, ex);
      chk("R4 irq_oe", {7'b0, irq_oe_o}, {7'b0, |(st & m_mask)});
      chk("R4 irq_n",  {7'b0, irq_n_o},  {7'b0, ~|(st & m_mask)});
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; tx_rdy_i = 0; rx_rdy_i = 0; brk_i = 0; brk_clr_i = 0; mpi_i = 2'b11;
    ct_done_i = 0; sample_tick_i = 0; reg_sel_i = 0; rd_i = 0; wr_i = 0; wdata_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 status in reset", rdata_o, 8'h00);
    chk("R1 irq_oe in reset", {7'b0, irq_oe_o}, 8'h00);
    chk("R1 irq_n in reset",  {7'b0, irq_n_o},  8'h01);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    reg_sel_i = 2'd1;
    @(negedge clk_i) chk("R1 mask after reset", rdata_o, 8'h00);
    reg_sel_i = 2'd2;
    @(negedge clk_i) chk("R1 input change after reset", rdata_o, 8'h03);

    // unmasked status, masked request
    step(1); tx_rdy_i = 2'b01; reg_sel_i = 2'd0;
    @(negedge clk_i);
    chk("R3 status unmasked", rdata_o, 8'h01);
    chk("R4 no request with mask 0", {7'b0, irq_oe_o}, 8'h00);
    step(1); wr_i = 1; reg_sel_i = 2'd1; wdata_i = 8'h01;
    step(1); wr_i = 0;
    @(negedge clk_i);
    chk("R5 mask readback", rdata_o, 8'h01);
    chk("R5 request after mask write", {7'b0, irq_oe_o}, 8'h01);

    // bit layout
    step(1); tx_rdy_i = 2'b00; rx_rdy_i = 2'b10; ct_done_i = 1; reg_sel_i = 2'd0;
    @(negedge clk_i) chk("R2 rx ch1 and counter bits", rdata_o, 8'h28);
    step(1); rx_rdy_i = 2'b01; tx_rdy_i = 2'b10; ct_done_i = 0;
    @(negedge clk_i) chk("R2 rx ch0 and tx ch1 bits", rdata_o, 8'h12);
    step(1); rx_rdy_i = 0; tx_rdy_i = 0;

    // break change flags
    brk_i = 2'b10;
    step(1);
    @(negedge clk_i) chk("R6 break rise ch1", rdata_o, 8'h40);
    step(1); brk_clr_i = 2'b10;
    step(1); brk_clr_i = 2'b00;
    @(negedge clk_i) chk("R6 break flag cleared", rdata_o, 8'h00);
    step(1); brk_i = 2'b00; brk_clr_i = 2'b10;
    step(1); brk_clr_i = 2'b00;
    @(negedge clk_i) chk("R6 edge beats clear", rdata_o, 8'h40);
    step(1); brk_i = 2'b01; brk_clr_i = 2'b10;
    step(1); brk_clr_i = 2'b01;
    step(1); brk_clr_i = 2'b00;
    @(negedge clk_i) chk("R6 ch0 edge cleared, ch1 cleared", rdata_o, 8'h00);

    // input filter: one-tick glitch is dropped
    step(1); mpi_i = 2'b10;
    step(3); sample_tick_i = 1;
    step(1); sample_tick_i = 0; mpi_i = 2'b11;
    step(4); sample_tick_i = 1;
    step(2); sample_tick_i = 0; reg_sel_i = 2'd2;
    @(negedge clk_i) chk("R7 glitch ignored", rdata_o, 8'h03);
    // held change accepted
    step(1); mpi_i = 2'b10;
    step(3); sample_tick_i = 1;
    step(2); sample_tick_i = 0;
    @(negedge clk_i) chk("R7 change accepted", rdata_o, 8'h12);
    step(1); reg_sel_i = 2'd0;
    @(negedge clk_i) chk("R2 input change bit", rdata_o, 8'h80);
    step(1); reg_sel_i = 2'd2; rd_i = 1;
    step(1); rd_i = 0;
    @(negedge clk_i) chk("R8 read clears flag", rdata_o, 8'h02);
    // acceptance coincident with clearing read
    step(1); mpi_i = 2'b11;
    step(3); sample_tick_i = 1;
    step(1); rd_i = 1;
    step(1); rd_i = 0; sample_tick_i = 0;
    @(negedge clk_i) chk("R8 new change survives read", rdata_o, 8'h13);

    // writes to other selects
    step(1); wr_i = 1; wdata_i = 8'hFF; reg_sel_i = 2'd0;
    step(1); reg_sel_i = 2'd2;
    step(1); reg_sel_i = 2'd3;
    step(1); wr_i = 0; reg_sel_i = 2'd1;
    @(negedge clk_i) chk("R9 mask untouched", rdata_o, 8'h01);
    step(1); reg_sel_i = 2'd2;
    @(negedge clk_i) chk("R9 input change untouched", rdata_o, 8'h13);
    step(1); reg_sel_i = 2'd3;
    @(negedge clk_i) chk("R9 unused select reads zero", rdata_o, 8'h00);

    // random mix, compared every cycle by the model
    for (int k = 0; k < 6000; k++) begin
      step(1);
      tx_rdy_i = 2'($urandom); rx_rdy_i = 2'($urandom);
      ct_done_i = ($urandom % 4) == 0;
      brk_i = (($urandom % 8) == 0) ? ~brk_i : brk_i;
      brk_clr_i = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      mpi_i = (($urandom % 10) == 0) ? 2'($urandom) : mpi_i;
      sample_tick_i = ($urandom % 3) == 0;
      reg_sel_i = 2'($urandom);
      rd_i = ($urandom % 4) == 0;
      wr_i = ($urandom % 8) == 0;
      wdata_i = 8'($urandom);
    end
    step(1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule